// File: doc/BRIEF.md
# TDM Timeslot Buffer Address Mapper

This block sits between a 32-timeslot serial TDM frame and a pair of byte buffers. It follows the frame from an active-low frame pulse and a bit-rate clock running at two clocks per data bit, so each timeslot lasts 16 clocks. For every timeslot it presents the buffer address of that channel. It serialises the byte it reads from the transmit buffer onto the outgoing line, most significant bit first. It gathers the incoming line into a byte and hands that byte, with its address, to the receive buffer once the timeslot ends.

A single configuration input selects one of two mappings. When `mode32` is high, buffer location n belongs to timeslot n for all 32 timeslots. When it is low, only 24 buffer locations are used. Every timeslot whose number is a multiple of four is then a filler: it transmits all ones, consumes no buffer location, and its received byte is discarded. The 24 locations fill the remaining timeslots in ascending order. The same mapping serves both directions.

Top module: `tdm_chan_mapper`

## Requirements
- R1: A frame is 32 timeslots of 16 clocks each, 512 clocks in all. When `frameSync_n` is sampled low at a rising edge, the block is at timeslot 0, slot count 0 in the following cycle. Otherwise it advances one count per clock and wraps from timeslot 31 to timeslot 0.
- R2: With `mode32` = 1, `bufAddr` equals the current timeslot number and `fillSlot` is 0.
- R3: With `mode32` = 0, timeslots 0, 4, 8, 12, 16, 20, 24 and 28 are fillers: `fillSlot` = 1 and `bufAddr` = 0.
- R4: With `mode32` = 0, non-filler timeslot n gives `bufAddr` = n - floor(n/4) - 1, so the addresses 0 to 23 appear in ascending order over a frame and never reach 24.
- R5: `txByte` is captured at the rising edge where the slot count is 0. Its bit 7-i is then driven on `serTx` during slot counts 2i+1 and 2i+2. For bit 0, count 16 is count 0 of the next timeslot.
- R6: A filler timeslot transmits eight ones, whatever value `txByte` has.
- R7: `serRx` is sampled at the rising edge where the slot count is 2i+1 and gives bit 7-i of the received byte, most significant bit first.
- R8: At the rising edge that ends a non-filler timeslot (count 15), `rxWrite` is raised for exactly one cycle together with `rxAddr`, the buffer address of that timeslot, and `rxData`, the byte it received.
- R9: A filler timeslot never raises `rxWrite`.
- R10: While `rst_n` is low, the block is at timeslot 0, count 0, with `serTx` = 1, `rxWrite` = 0, `rxAddr` = 0 and `rxData` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, two periods per data bit |
| rst_n | input | 1 | Active-low synchronous reset |
| frameSync_n | input | 1 | Active-low frame alignment pulse |
| mode32 | input | 1 | 1 maps all 32 timeslots, 0 maps 24 with fillers |
| txByte | input | 8 | Transmit buffer byte at `bufAddr` |
| serRx | input | 1 | Incoming serial line |
| bufAddr | output | 5 | Buffer address of the current timeslot |
| fillSlot | output | 1 | Current timeslot is a filler |
| serTx | output | 1 | Outgoing serial line |
| rxWrite | output | 1 | One-cycle receive buffer write strobe |
| rxAddr | output | 5 | Receive buffer write address |
| rxData | output | 8 | Received byte to write |

## Verification
A slot counter that has drifted shows at `bufAddr` within one clock after a timeslot boundary. It also shows as a `rxWrite` pulse in the wrong cycle at the end of the next timeslot. An error in the address arithmetic shows in the first 24-channel timeslot after a filler. A shifter that is out of step corrupts `serTx` one clock after a timeslot starts, and `rxData` 16 clocks later. The bench therefore compares every output on every clock. It does so in both mappings, across a mapping change, with and without frame pulses, and through a resynchronisation that comes in the middle of a frame.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;

  // Per-cycle commands from the slot sequencer to the datapath
  typedef struct packed {
    logic loadTx;    // slot start: capture the transmit byte
    logic shiftTx;   // bit boundary: advance the transmit shifter
    logic sampleRx;  // bit centre: take one receive bit
    logic commitRx;  // last receive bit of the slot
    logic fillNow;   // current slot is a filler
  } mapStrobe_t;

endpackage

// File: rtl/tdm_map_ctrl.sv
module tdm_map_ctrl
  import tdm_map_pkg::*;
#(
  parameter int NUM_SLOTS    = 32,
  parameter int SLOT_BITS    = 8,
  parameter int CLKS_PER_BIT = 2,
  parameter int FILL_STRIDE  = 4,
  parameter int ADDR_W       = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameSync_n,
  input  logic              mode32,
  output mapStrobe_t        strobe,
  output logic [ADDR_W-1:0] slotAddr
);

  localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);
  localparam logic [ADDR_W-1:0] SLOT_LAST = ADDR_W'(NUM_SLOTS - 1);
  localparam bit STRIDE_POW2 = (FILL_STRIDE & (FILL_STRIDE - 1)) == 0;

  logic [PH_W-1:0]   phaseCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] slotCnt;

  // Position in the frame: phase within bit, bit within slot, slot
  always_ff @(posedge clk) begin
    if (!rst_n || !frameSync_n) begin
      phaseCnt <= '0;
      bitCnt   <= '0;
      slotCnt  <= '0;
    end else if (phaseCnt == PH_LAST) begin
      phaseCnt <= '0;
      if (bitCnt == BIT_LAST) begin
        bitCnt  <= '0;
        slotCnt <= (slotCnt == SLOT_LAST) ? '0 : slotCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // Group of FILL_STRIDE slots and member within it
  logic [ADDR_W-1:0] groupIdx;
  logic [ADDR_W-1:0] memberIdx;

  generate
    if (STRIDE_POW2) begin : g_shift
      localparam int STRIDE_LG = $clog2(FILL_STRIDE);
      assign groupIdx  = slotCnt >> STRIDE_LG;
      assign memberIdx = slotCnt & ADDR_W'(FILL_STRIDE - 1);
    end else begin : g_div
      localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(FILL_STRIDE);
      assign groupIdx  = slotCnt / STRIDE_V;
      assign memberIdx = slotCnt % STRIDE_V;
    end
  endgenerate

  logic isFillPos;
  logic [ADDR_W-1:0] denseAddr;

  assign isFillPos = (memberIdx == '0);
  // Each group before this slot owns one filler, plus this group's own
  assign denseAddr = slotCnt - groupIdx - ADDR_W'(1);

  always_comb begin
    strobe.fillNow  = !mode32 && isFillPos;
    strobe.loadTx   = (phaseCnt == '0) && (bitCnt == '0);
    strobe.shiftTx  = (phaseCnt == '0) && (bitCnt != '0);
    strobe.sampleRx = (phaseCnt == PH_LAST);
    strobe.commitRx = (phaseCnt == PH_LAST) && (bitCnt == BIT_LAST);
    if (mode32)             slotAddr = slotCnt;
    else if (strobe.fillNow) slotAddr = '0;
    else                     slotAddr = denseAddr;
  end

endmodule

// File: rtl/tdm_map_dp.sv
module tdm_map_dp
  import tdm_map_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  mapStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    slotAddr,
  input  logic [SLOT_BITS-1:0] txByte,
  input  logic                 serRx,
  output logic                 serTx,
  output logic                 rxWrite,
  output logic [ADDR_W-1:0]    rxAddr,
  output logic [SLOT_BITS-1:0] rxData
);

  logic [SLOT_BITS-1:0] txShift;
  logic [SLOT_BITS-1:0] rxShift;
  logic [SLOT_BITS-1:0] rxNext;

  assign rxNext = {rxShift[SLOT_BITS-2:0], serRx};
  assign serTx  = txShift[SLOT_BITS-1];

  // Transmit: parallel load at slot start, shift left with ones fill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '1;
    end else if (strobe.loadTx) begin
      txShift <= strobe.fillNow ? '1 : txByte;
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[SLOT_BITS-2:0], 1'b1};
    end
  end

  // Receive: collect bits, hand over a whole byte on the last one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift <= '0;
      rxWrite <= 1'b0;
      rxAddr  <= '0;
      rxData  <= '0;
    end else begin
      rxWrite <= strobe.commitRx && !strobe.fillNow;
      if (strobe.sampleRx) rxShift <= rxNext;
      if (strobe.commitRx && !strobe.fillNow) begin
        rxAddr <= slotAddr;
        rxData <= rxNext;
      end
    end
  end

endmodule

// File: rtl/tdm_chan_mapper.sv
module tdm_chan_mapper
  import tdm_map_pkg::*;
#(
  parameter int NUM_SLOTS    = 32,
  parameter int SLOT_BITS    = 8,
  parameter int CLKS_PER_BIT = 2,
  parameter int FILL_STRIDE  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frameSync_n,
  input  logic                         mode32,
  input  logic [SLOT_BITS-1:0]         txByte,
  input  logic                         serRx,
  output logic [$clog2(NUM_SLOTS)-1:0] bufAddr,
  output logic                         fillSlot,
  output logic                         serTx,
  output logic                         rxWrite,
  output logic [$clog2(NUM_SLOTS)-1:0] rxAddr,
  output logic [SLOT_BITS-1:0]         rxData
);

  localparam int ADDR_W = $clog2(NUM_SLOTS);

  mapStrobe_t        strobe;
  logic [ADDR_W-1:0] slotAddr;

  tdm_map_ctrl #(
    .NUM_SLOTS   (NUM_SLOTS),
    .SLOT_BITS   (SLOT_BITS),
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .FILL_STRIDE (FILL_STRIDE),
    .ADDR_W      (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frameSync_n(frameSync_n),
    .mode32     (mode32),
    .strobe     (strobe),
    .slotAddr   (slotAddr)
  );

  tdm_map_dp #(
    .SLOT_BITS(SLOT_BITS),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .slotAddr(slotAddr),
    .txByte  (txByte),
    .serRx   (serRx),
    .serTx   (serTx),
    .rxWrite (rxWrite),
    .rxAddr  (rxAddr),
    .rxData  (rxData)
  );

  assign bufAddr  = slotAddr;
  assign fillSlot = strobe.fillNow;

endmodule

// File: rtl/tdm_chan_mapper_chk.sv
module tdm_chan_mapper_chk #(
  parameter int NUM_SLOTS   = 32,
  parameter int FILL_STRIDE = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         frameSync_n,
  input logic                         mode32,
  input logic [$clog2(NUM_SLOTS)-1:0] bufAddr,
  input logic                         fillSlot,
  input logic                         serTx,
  input logic                         rxWrite
);

  localparam int DATA_SLOTS = NUM_SLOTS - NUM_SLOTS / FILL_STRIDE;

  // R4: the reduced mapping stays inside its 24 locations
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    !mode32 |-> (int'(bufAddr) < DATA_SLOTS));

  // R1: a frame pulse lands on timeslot 0
  a_r1_sync_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    !frameSync_n |=> (mode32 ? (bufAddr == '0 && !fillSlot) : fillSlot));

  // R6: once inside a filler timeslot the line carries ones
  a_r6_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (fillSlot && $past(fillSlot)) |-> serTx);

  // R9: no buffer write follows a filler timeslot
  a_r9_no_fill_write: assert property (@(posedge clk) disable iff (!rst_n)
    rxWrite |-> !$past(fillSlot));

  // R8: the write strobe lasts one cycle
  a_r8_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rxWrite |=> !rxWrite);

endmodule

bind tdm_chan_mapper tdm_chan_mapper_chk #(
  .NUM_SLOTS  (NUM_SLOTS),
  .FILL_STRIDE(FILL_STRIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frameSync_n(frameSync_n),
  .mode32     (mode32),
  .bufAddr    (bufAddr),
  .fillSlot   (fillSlot),
  .serTx      (serTx),
  .rxWrite    (rxWrite)
);

// File: tb/tb_tdm_chan_mapper.sv
module tb_tdm_chan_mapper;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frameSync_n = 1'b1;
  logic       mode32 = 1'b1;
  logic [7:0] txByte;
  logic       serRx = 1'b0;
  logic [4:0] bufAddr;
  logic       fillSlot;
  logic       serTx;
  logic       rxWrite;
  logic [4:0] rxAddr;
  logic [7:0] rxData;

  logic [7:0] txMem [32];

  always #5 clk = ~clk;

  tdm_chan_mapper dut (
    .clk(clk), .rst_n(rst_n), .frameSync_n(frameSync_n), .mode32(mode32),
    .txByte(txByte), .serRx(serRx), .bufAddr(bufAddr), .fillSlot(fillSlot),
    .serTx(serTx), .rxWrite(rxWrite), .rxAddr(rxAddr), .rxData(rxData)
  );

  assign txByte = txMem[bufAddr];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  int mPos, mBit, mFrame;
  logic [7:0] mByte;
  bit expWrite;
  int expAddr;
  logic [7:0] expData;

  function automatic bit isFill(int ch, logic m32);
    return !m32 && (ch % 4 == 0);
  endfunction

  function automatic int mapAddr(int ch, logic m32);
    if (m32) return ch;
    if (ch % 4 == 0) return 0;
    return ch - ch / 4 - 1;
  endfunction

  function automatic logic [7:0] rxSrc(int ch, int fr);
    return 8'((ch * 53) ^ (fr * 29) ^ 165);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at pos %0d: actual %0h expected %0h", req, mPos, act, exp);
    end
  endtask

  task automatic fillTx(int seed);
    for (int i = 0; i < 32; i++) txMem[i] = 8'(i * 37 + seed * 11 + 5);
  endtask

  // Compare all outputs against the reference at the current position
  task automatic compareAll();
    int ch;
    ch = mPos / 16;
    if (mode32) chk(bufAddr == 5'(ch), "R2 bufAddr", bufAddr, ch);
    else if (isFill(ch, mode32)) chk(bufAddr == 5'd0, "R3 bufAddr", bufAddr, 0);
    else chk(int'(bufAddr) == mapAddr(ch, mode32), "R4 bufAddr", bufAddr, mapAddr(ch, mode32));
    chk(fillSlot == isFill(ch, mode32), "R3 fillSlot", fillSlot, isFill(ch, mode32));
    if (mByte == 8'hFF) chk(serTx == 1'b1, "R6 serTx", serTx, 1);
    else chk(serTx == mByte[7-mBit], "R5 serTx", serTx, mByte[7-mBit]);
    chk(rxWrite == expWrite, expWrite ? "R8 rxWrite" : "R9 rxWrite", rxWrite, expWrite);
    if (expWrite && rxWrite) begin
      chk(int'(rxAddr) == expAddr, "R8 rxAddr", rxAddr, expAddr);
      chk(rxData == expData, "R7 rxData", rxData, expData);
    end
  endtask

  // One clock: drive inputs, advance the reference, compare at negedge
  task automatic step(logic fsN);
    int p, ch, c;
    p = mPos; ch = p / 16; c = p % 16;
    frameSync_n = fsN;
    serRx = rxSrc(ch, mFrame)[7 - c / 2];
    @(posedge clk);
    if (c == 0) begin
      mByte = isFill(ch, mode32) ? 8'hFF : txMem[mapAddr(ch, mode32)];
      mBit = 0;
    end else if (c % 2 == 0) begin
      mBit++;
    end
    expWrite = 1'b0;
    if (c == 15 && !isFill(ch, mode32)) begin
      expWrite = 1'b1;
      expAddr = mapAddr(ch, mode32);
      expData = rxSrc(ch, mFrame);
    end
    if (!fsN) begin
      mPos = 0; mFrame++;
    end else begin
      mPos = (p + 1) % 512;
      if (mPos == 0) mFrame++;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic runFrames(int n, bit pulses, int resyncAt);
    bit resynced = 1'b0;
    for (int k = 0; k < n * 512; k++) begin
      if (!resynced && mPos == resyncAt) begin
        resynced = 1'b1;
        step(1'b0);
      end else begin
        step((pulses && mPos == 511) ? 1'b0 : 1'b1);
      end
    end
  endtask

  task automatic alignFrame();
    while (mPos != 0) step(1'b1);
  endtask

  initial begin
    fillTx(0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(serTx == 1'b1, "R10 serTx", serTx, 1);
    chk(rxWrite == 1'b0, "R10 rxWrite", rxWrite, 0);
    chk(rxAddr == 5'd0, "R10 rxAddr", rxAddr, 0);
    chk(rxData == 8'd0, "R10 rxData", rxData, 0);
    chk(bufAddr == 5'd0, "R10 bufAddr", bufAddr, 0);
    mPos = 0; mBit = 0; mFrame = 0; mByte = 8'hFF; expWrite = 1'b0;
    expAddr = 0; expData = 8'd0;
    rst_n = 1'b1;

    // Full mapping, aligned frame pulses
    runFrames(2, 1'b1, -1);
    alignFrame();

    // Reduced mapping, new transmit contents
    mode32 = 1'b0;
    fillTx(3);
    runFrames(2, 1'b1, -1);
    alignFrame();

    // R1: resynchronise in the middle of a frame
    runFrames(1, 1'b1, 200);
    chk(fillSlot == 1'b1 || mPos / 16 % 4 != 0, "R1 resync", fillSlot, 1);
    alignFrame();
    step(1'b1);
    chk(fillSlot == 1'b1 && bufAddr == 5'd0, "R1 slot0 after wrap", fillSlot, 1);
    alignFrame();

    // Full mapping again, free running without pulses
    mode32 = 1'b1;
    fillTx(7);
    runFrames(2, 1'b0, -1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired at pos %0d: actual 0 expected 1", mPos);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule